// File: doc/BRIEF.md
# Dual-Channel Bus-Master Disk DMA Register Block

This block holds the software-visible registers of a two-channel bus-master disk DMA controller. A host reaches it through a 16-byte I/O window with byte, halfword and word accesses. Each channel has a command byte, a status byte, a vendor timing byte and a 32-bit descriptor-table pointer. A vendor mode byte is shared by both channels and appears in both halves of the window.

A command write drives the external DMA engine through one-cycle start and stop strobes. The engine reports completion on a done input. The two drive-channel interrupt levels are latched into the shared mode byte. Each level is gated by its own per-channel mask bit, and the two gated levels are merged into a single interrupt output.

A build parameter selects a generic variant. In that variant the two vendor bytes read as 0xFF, writes to them are dropped, and the interrupt output is the plain OR of both channel levels.

Top module: `bmide_regs`

## Requirements
- R1: Address bit 3 selects the channel (0 for offsets 0-7, 1 for offsets 8-15), and both halves share one layout: 0 command, 1 mode, 2 status, 3 timing, 4-7 pointer. An access wider than a byte at offsets 0-3 acts only on the byte it addresses, and a read returns that byte zero-extended.
- R2: A command write stores only bit 0 (run) and bit 3 (direction), so the readback is the written value ANDed with 0x09. Command bit 3 is driven on `dma_dir`.
- R3: A command write with bit 0 set while status bit 0 (active) is clear sets the active bit and pulses `dma_start` for one cycle after the write edge. If the active bit is already set, no start pulse is issued. A command write with bit 0 clear pulses `dma_cancel` for one cycle and clears the active bit.
- R4: A status write works bit by bit:
  - bits 6:5 take the written value;
  - bit 0 keeps its value;
  - bits 2:1 are cleared where a 1 is written;
  - bits 7, 4 and 3 always read 0.
- R5: Pointer writes of byte, halfword or word size at offsets 4-7 replace only the addressed bytes, and bits 1:0 are forced to 0. Each pointer write loads the current-address output (`cur_addr0`/`cur_addr1`) at the same edge.
- R6: A pointer read returns the stored pointer shifted right by 8 x (offset - 4) and masked to the access width.
- R7: The mode byte is shared by both channels. Bit 2 holds the latched channel 0 level, bit 3 the channel 1 level, bit 4 the channel 0 mask and bit 5 the channel 1 mask. Other bits read 0. A write through either offset 1 or 9 changes only bits 5:4.
- R8: `irq_out` = (bit 2 AND NOT bit 4) OR (bit 3 AND NOT bit 5). It follows a change of `drv_irq` one clock later and a mask write at the write edge.
- R9: A `dma_done` pulse sets status bit 2 and clears status bit 0 of its channel. When it coincides with a status write, bit 2 ends up set.
- R10: Offset 3 of each channel is an independent read/write timing byte.
- R11: With VENDOR_EXT = 0, offsets 1, 3, 9 and 11 read 0x000000FF and writes to them are ignored. The masks stay 0, so `irq_out` is the OR of both levels.
- R12: While reset is asserted, all registers read 0, `dma_start` is 0 and `dma_cancel` is 2'b11. The cancel strobes drop at the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset in the window |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, right-justified |
| bus_rdata | output | 32 | Read data for the addressed register, right-justified |
| drv_irq | input | 2 | Interrupt level from each drive channel |
| dma_done | input | 2 | Per-channel transfer-complete pulse |
| dma_start | output | 2 | Per-channel start strobe |
| dma_cancel | output | 2 | Per-channel stop strobe |
| dma_dir | output | 2 | Per-channel direction (command bit 3) |
| cur_addr0 | output | 32 | Channel 0 current descriptor pointer |
| cur_addr1 | output | 32 | Channel 1 current descriptor pointer |
| irq_out | output | 1 | Merged, masked interrupt |

## Verification
A wrong active bit shows up one cycle after the next run command: the start strobe either appears when it should be suppressed or is missing. A wrong mask or latched level shows up on `irq_out` in the cycle after the register changes. A corrupted pointer byte is visible on the current-address port at the edge of the write that produced it. The reference model compares the strobes, direction, interrupt and both pointers every cycle, so any such error is reported within one clock. Status and mode bits that drive no output are checked by reading them back right after the stimulus.

// File: rtl/bmide_pkg.sv
package bmide_pkg;
  localparam int CH_NUM    = 2;
  localparam int REG_W     = 32;
  localparam int REG_BYTES = REG_W / 8;
  localparam int OFF_W     = 3;
  localparam int WIN_AW    = OFF_W + 1;

  localparam logic [OFF_W-1:0] OFF_CMD  = 3'd0;
  localparam logic [OFF_W-1:0] OFF_MODE = 3'd1;
  localparam logic [OFF_W-1:0] OFF_STAT = 3'd2;
  localparam logic [OFF_W-1:0] OFF_TIME = 3'd3;

  localparam logic [7:0] CMD_KEEP = 8'h09;
  localparam int CMD_RUN  = 0;
  localparam int CMD_DIR  = 3;
  localparam int ST_ACT   = 0;
  localparam int ST_INT   = 2;
  localparam int MODE_LVL = 2;
  localparam int MODE_BLK = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;
endpackage

// File: rtl/bmide_irq.sv
module bmide_irq
  import bmide_pkg::*;
#(
  parameter bit VENDOR_EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_NUM-1:0] irq_in,
  input  logic              blk_wr_i,
  input  logic [CH_NUM-1:0] blk_wdata_i,
  output logic [7:0]        mode_o,
  output logic              irq_o
);
  logic [CH_NUM-1:0] lvl_q, lvl_d;
  logic [CH_NUM-1:0] blk_q;
  logic [CH_NUM-1:0] gated;
  logic              up_q;

  assign lvl_d = irq_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      up_q  <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      up_q  <= 1'b1;
    end
  end

  if (VENDOR_EXT) begin : g_blk
    logic [CH_NUM-1:0] blk_d;
    logic              blk_en;
    assign blk_en = blk_wr_i;
    assign blk_d  = blk_wdata_i;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      blk_q <= '0;
      else if (blk_en) blk_q <= blk_d;
    end
  end else begin : g_noblk
    assign blk_q = '0;
  end

  for (genvar c = 0; c < CH_NUM; c++) begin : g_gate
    assign gated[c] = lvl_q[c] & ~blk_q[c];
  end

  assign irq_o  = |gated;
  assign mode_o = {2'b00, blk_q, lvl_q, 2'b00};

  // R8: with no level in the previous cycle, the output is low
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !$past(|irq_in)) |-> !irq_o);
  // R8: an unmasked channel 0 level reaches the output one cycle later
  a_r8_pass_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(irq_in[0]) && !blk_q[0]) |-> irq_o);
  // R7: mask bits move only after a mode write
  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !$past(blk_wr_i)) |-> $stable(blk_q));
endmodule

// File: rtl/bmide_chan.sv
module bmide_chan
  import bmide_pkg::*;
#(
  parameter bit VENDOR_EXT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             done_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             start_o,
  output logic             cancel_o,
  output logic             dir_o,
  output logic [REG_W-1:0] cur_addr_o
);
  logic [7:0]           cmd_q, cmd_d;
  logic                 cmd_en;
  logic [7:0]           st_q, st_d;
  logic                 st_en;
  logic [REG_W-1:0]     addr_q, addr_d, cur_q, addr_merge, wd_sh;
  logic                 addr_en;
  logic [REG_BYTES-1:0] be_base, addr_be;
  logic                 start_q, start_d, cancel_q, cancel_d;
  logic                 wr_cmd, wr_st, wr_tim;
  logic [7:0]           tim_rd;
  logic [REG_W-1:0]     rd_mask, addr_rd;
  logic                 up_q;

  assign wr_cmd = wr_i && (off_i == OFF_CMD);
  assign wr_st  = wr_i && (off_i == OFF_STAT);
  assign wr_tim = wr_i && (off_i == OFF_TIME);

  // command and status next state
  always_comb begin
    cmd_d    = wdata_i[7:0] & CMD_KEEP;
    cmd_en   = wr_cmd;
    st_d     = st_q;
    start_d  = 1'b0;
    cancel_d = 1'b0;
    if (wr_st) begin
      st_d = {1'b0, wdata_i[6:5], 2'b00, st_q[2:1] & ~wdata_i[2:1], st_q[0]};
    end
    if (wr_cmd) begin
      if (!wdata_i[CMD_RUN]) begin
        cancel_d       = 1'b1;
        st_d[ST_ACT]   = 1'b0;
      end else if (!st_q[ST_ACT]) begin
        start_d        = 1'b1;
        st_d[ST_ACT]   = 1'b1;
      end
    end
    if (done_i) begin
      st_d[ST_INT] = 1'b1;
      if (!start_d) st_d[ST_ACT] = 1'b0;
    end
    st_en = wr_cmd | wr_st | done_i;
  end

  // pointer byte lanes
  always_comb begin
    unique case (size_i)
      SZ_BYTE: be_base = 4'b0001;
      SZ_HALF: be_base = 4'b0011;
      default: be_base = 4'b1111;
    endcase
    addr_be = (wr_i && off_i[OFF_W-1]) ? (be_base << off_i[1:0]) : '0;
    wd_sh   = wdata_i << {off_i[1:0], 3'b000};
    addr_en = |addr_be;
  end

  for (genvar b = 0; b < REG_BYTES; b++) begin : g_lane
    assign addr_merge[b*8 +: 8] = addr_be[b] ? wd_sh[b*8 +: 8] : addr_q[b*8 +: 8];
  end
  assign addr_d = {addr_merge[REG_W-1:2], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      st_q     <= '0;
      addr_q   <= '0;
      cur_q    <= '0;
      start_q  <= 1'b0;
      cancel_q <= 1'b1;
      up_q     <= 1'b0;
    end else begin
      up_q     <= 1'b1;
      start_q  <= start_d;
      cancel_q <= cancel_d;
      if (cmd_en) cmd_q <= cmd_d;
      if (st_en)  st_q  <= st_d;
      if (addr_en) begin
        addr_q <= addr_d;
        cur_q  <= addr_d;
      end
    end
  end

  if (VENDOR_EXT) begin : g_tim
    logic [7:0] tim_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tim_q <= '0;
      else if (wr_tim) tim_q <= wdata_i[7:0];
    end
    assign tim_rd = tim_q;
  end else begin : g_notim
    assign tim_rd = 8'hFF;
  end

  // read path
  always_comb begin
    unique case (size_i)
      SZ_BYTE: rd_mask = 32'h0000_00FF;
      SZ_HALF: rd_mask = 32'h0000_FFFF;
      default: rd_mask = '1;
    endcase
    addr_rd = (addr_q >> {off_i[1:0], 3'b000}) & rd_mask;
    if (off_i[OFF_W-1]) begin
      rdata_o = addr_rd;
    end else begin
      unique case (off_i[1:0])
        2'd0:    rdata_o = {24'b0, cmd_q};
        2'd2:    rdata_o = {24'b0, st_q};
        2'd3:    rdata_o = {24'b0, tim_rd};
        default: rdata_o = '0;
      endcase
    end
  end

  assign start_o    = start_q;
  assign cancel_o   = cancel_q;
  assign dir_o      = cmd_q[CMD_DIR];
  assign cur_addr_o = cur_q;

  // R3: a start pulse only leaves an idle channel, which becomes active
  a_r3_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && start_o) |-> (st_q[ST_ACT] && !$past(st_q[ST_ACT])));
  // R3: start and stop never together
  a_r3_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && cancel_o));
  // R4: reserved status bits stay zero
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[7] == 1'b0) && (st_q[4:3] == 2'b00));
  // R4: writing 1 to the interrupt bit clears it when no done arrives
  a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(wr_st) && $past(wdata_i[ST_INT]) && !$past(done_i)) |-> !st_q[ST_INT]);
  // R9: done sets the interrupt bit
  a_r9_done_int: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(done_i)) |-> st_q[ST_INT]);
  // R5: the pointer only changes after a pointer write
  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !$past(addr_en)) |-> $stable(addr_q));
endmodule

// File: rtl/bmide_regs.sv
module bmide_regs
  import bmide_pkg::*;
#(
  parameter bit VENDOR_EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [WIN_AW-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [CH_NUM-1:0] drv_irq,
  input  logic [CH_NUM-1:0] dma_done,
  output logic [CH_NUM-1:0] dma_start,
  output logic [CH_NUM-1:0] dma_cancel,
  output logic [CH_NUM-1:0] dma_dir,
  output logic [REG_W-1:0]  cur_addr0,
  output logic [REG_W-1:0]  cur_addr1,
  output logic              irq_out
);
  logic [OFF_W-1:0] off;
  logic             wr_any;
  logic             mode_wr;
  logic [7:0]       mode_byte;
  logic [REG_W-1:0] chan_rd  [CH_NUM];
  logic [REG_W-1:0] chan_cur [CH_NUM];

  assign off     = bus_addr[OFF_W-1:0];
  assign wr_any  = bus_sel && bus_we;
  assign mode_wr = wr_any && (off == OFF_MODE);

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    bmide_chan #(.VENDOR_EXT(VENDOR_EXT)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (wr_any && (bus_addr[OFF_W] == 1'(c))),
      .off_i      (off),
      .size_i     (bus_size),
      .wdata_i    (bus_wdata),
      .done_i     (dma_done[c]),
      .rdata_o    (chan_rd[c]),
      .start_o    (dma_start[c]),
      .cancel_o   (dma_cancel[c]),
      .dir_o      (dma_dir[c]),
      .cur_addr_o (chan_cur[c])
    );
  end

  bmide_irq #(.VENDOR_EXT(VENDOR_EXT)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_in      (drv_irq),
    .blk_wr_i    (mode_wr),
    .blk_wdata_i (bus_wdata[MODE_BLK +: CH_NUM]),
    .mode_o      (mode_byte),
    .irq_o       (irq_out)
  );

  always_comb begin
    if (off == OFF_MODE) begin
      bus_rdata = VENDOR_EXT ? {24'b0, mode_byte} : 32'h0000_00FF;
    end else begin
      bus_rdata = chan_rd[bus_addr[OFF_W]];
    end
  end

  assign cur_addr0 = chan_cur[0];
  assign cur_addr1 = chan_cur[1];

  // R1: one access per cycle, so at most one channel starts at a time
  a_r1_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dma_start));
endmodule

// File: tb/tb_bmide_regs.sv
`timescale 1ns/1ps
module tb_bmide_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_sel = 1'b0, b_we = 1'b0;
  logic [3:0]  b_addr = '0;
  logic [1:0]  b_size = '0;
  logic [31:0] b_wdata = '0;
  logic [1:0]  b_drv = '0, b_done = '0;
  logic [31:0] rdata, rdata_g, cur0, cur1, cur0_g, cur1_g;
  logic [1:0]  dma_start, dma_cancel, dma_dir, st_g, ca_g, dir_g;
  logic        irq, irq_g;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bmide_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(b_sel), .bus_we(b_we), .bus_addr(b_addr),
    .bus_size(b_size), .bus_wdata(b_wdata), .bus_rdata(rdata), .drv_irq(b_drv),
    .dma_done(b_done), .dma_start(dma_start), .dma_cancel(dma_cancel),
    .dma_dir(dma_dir), .cur_addr0(cur0), .cur_addr1(cur1), .irq_out(irq));

  bmide_regs #(.VENDOR_EXT(1'b0)) dut_gen (
    .clk(clk), .rst_n(rst_n), .bus_sel(b_sel), .bus_we(b_we), .bus_addr(b_addr),
    .bus_size(b_size), .bus_wdata(b_wdata), .bus_rdata(rdata_g), .drv_irq(b_drv),
    .dma_done(b_done), .dma_start(st_g), .dma_cancel(ca_g),
    .dma_dir(dir_g), .cur_addr0(cur0_g), .cur_addr1(cur1_g), .irq_out(irq_g));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0]  m_cmd [2];
  logic [7:0]  m_st  [2];
  logic [31:0] m_addr[2];
  logic [1:0]  m_start, m_cancel, m_lvl, m_blk;

  always @(posedge clk) begin
    int c, o, n, j;
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_cmd[i] = 8'h00; m_st[i] = 8'h00; m_addr[i] = 32'h0;
      end
      m_start = 2'b00; m_cancel = 2'b11; m_lvl = 2'b00; m_blk = 2'b00;
    end else begin
      m_start = 2'b00; m_cancel = 2'b00;
      if (b_sel && b_we) begin
        c = int'(b_addr[3]);
        o = int'(b_addr[2:0]);
        n = (b_size == 2'd0) ? 1 : (b_size == 2'd1) ? 2 : 4;
        if (o == 0) begin
          m_cmd[c] = b_wdata[7:0] & 8'h09;
          if (!b_wdata[0]) begin
            m_cancel[c] = 1'b1; m_st[c][0] = 1'b0;
          end else if (!m_st[c][0]) begin
            m_start[c] = 1'b1; m_st[c][0] = 1'b1;
          end
        end else if (o == 1) begin
          m_blk = b_wdata[5:4];
        end else if (o == 2) begin
          m_st[c] = (b_wdata[7:0] & 8'h60) | (m_st[c] & 8'h01) | (m_st[c] & ~b_wdata[7:0] & 8'h06);
        end else if (o >= 4) begin
          for (int k = 0; k < n; k++) begin
            j = o - 4 + k;
            if (j < 4) m_addr[c][8*j +: 8] = b_wdata[8*k +: 8];
          end
          m_addr[c][1:0] = 2'b00;
        end
      end
      for (int i = 0; i < 2; i++) begin
        if (b_done[i]) begin
          m_st[i][2] = 1'b1;
          if (!m_start[i]) m_st[i][0] = 1'b0;
        end
      end
      m_lvl = b_drv;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3 start strobe", 32'(dma_start), 32'(m_start));
      chk("R3 cancel strobe", 32'(dma_cancel), 32'(m_cancel));
      chk("R2 direction", 32'(dma_dir), 32'({m_cmd[1][3], m_cmd[0][3]}));
      chk("R8 irq_out", 32'(irq), 32'(|(m_lvl & ~m_blk)));
      chk("R5 cur_addr0", cur0, m_addr[0]);
      chk("R5 cur_addr1", cur1, m_addr[1]);
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk); #1;
    b_sel = 1'b1; b_we = 1'b1; b_addr = a; b_size = sz; b_wdata = d;
    @(negedge clk); #1;
    b_sel = 1'b0; b_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] sz, input bit gen,
                    input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    b_addr = a; b_size = sz; #1;
    chk(tag, gen ? rdata_g : rdata, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R12: reset state
    chk("R12 cancel in reset", 32'(dma_cancel), 32'h3);
    chk("R12 start in reset", 32'(dma_start), 32'h0);
    rd(4'd2, 2'd0, 0, 32'h0, "R12 status0 reset");
    rd(4'd4, 2'd2, 0, 32'h0, "R12 pointer0 reset");
    rd(4'd1, 2'd0, 0, 32'h0, "R12 mode reset");
    @(negedge clk); #1 rst_n = 1'b1;
    wait_cyc(1);
    chk("R12 cancel drops after release", 32'(dma_cancel), 32'h0);

    // R2 / R3: command and start
    bus_wr(4'd0, 2'd0, 32'h0000_000F);
    rd(4'd0, 2'd0, 0, 32'h09, "R2 command mask");
    rd(4'd2, 2'd0, 0, 32'h01, "R3 active set by start");
    bus_wr(4'd0, 2'd0, 32'h0000_0001);
    chk("R3 no restart while active", 32'(dma_start), 32'h0);
    rd(4'd0, 2'd2, 0, 32'h01, "R1 wide read at offset 0");

    // R9 / R4
    @(negedge clk); #1 b_done = 2'b01;
    @(negedge clk); #1 b_done = 2'b00;
    rd(4'd2, 2'd0, 0, 32'h04, "R9 done sets int, clears active");
    bus_wr(4'd2, 2'd0, 32'h0000_00FF);
    rd(4'd2, 2'd0, 0, 32'h60, "R4 status write all ones");

    // channel 1 start, status keep, stop
    bus_wr(4'd8, 2'd0, 32'h0000_0009);
    rd(4'd10, 2'd0, 0, 32'h01, "R3 channel 1 active");
    bus_wr(4'd10, 2'd0, 32'h0000_0000);
    rd(4'd10, 2'd0, 0, 32'h01, "R4 active bit not writable");
    bus_wr(4'd8, 2'd0, 32'h0000_0008);
    rd(4'd10, 2'd0, 0, 32'h00, "R3 stop clears active");
    rd(4'd8, 2'd0, 0, 32'h08, "R2 direction stored");
    rd(4'd2, 2'd0, 0, 32'h60, "R1 channel 0 untouched");

    // R9: done coincides with clearing write
    @(negedge clk); #1;
    b_sel = 1'b1; b_we = 1'b1; b_addr = 4'd10; b_size = 2'd0; b_wdata = 32'h04; b_done = 2'b10;
    @(negedge clk); #1;
    b_sel = 1'b0; b_we = 1'b0; b_done = 2'b00;
    rd(4'd10, 2'd0, 0, 32'h04, "R9 done beats clear");
    bus_wr(4'd10, 2'd0, 32'h0000_0004);
    rd(4'd10, 2'd0, 0, 32'h00, "R4 write-one-to-clear");

    // R5 / R6: pointer
    bus_wr(4'd4, 2'd2, 32'h1234_5677);
    rd(4'd4, 2'd2, 0, 32'h1234_5674, "R5 word write low bits forced");
    bus_wr(4'd5, 2'd0, 32'h0000_00AB);
    rd(4'd5, 2'd0, 0, 32'h0000_00AB, "R6 byte read offset 5");
    rd(4'd4, 2'd2, 0, 32'h1234_AB74, "R5 byte write");
    bus_wr(4'd6, 2'd1, 32'h0000_BEEF);
    rd(4'd6, 2'd1, 0, 32'h0000_BEEF, "R6 half read offset 6");
    bus_wr(4'd4, 2'd0, 32'h0000_00FF);
    rd(4'd4, 2'd1, 0, 32'h0000_ABFC, "R6 half read offset 4");
    chk("R5 cur_addr0 reload", cur0, 32'hBEEF_ABFC);
    bus_wr(4'd12, 2'd2, 32'hFFFF_FFFF);
    rd(4'd12, 2'd2, 0, 32'hFFFF_FFFC, "R5 channel 1 pointer");
    rd(4'd7, 2'd0, 0, 32'h0000_00BE, "R6 byte read offset 7");
    rd(4'd4, 2'd2, 0, 32'hBEEF_ABFC, "R1 channel 0 pointer kept");

    // R7 / R8: mode byte and interrupt
    @(negedge clk); #1 b_drv = 2'b01;
    wait_cyc(1);
    chk("R8 level passes after one clock", 32'(irq), 32'h1);
    rd(4'd1, 2'd0, 0, 32'h04, "R7 level bit 2");
    bus_wr(4'd1, 2'd0, 32'h0000_00FF);
    rd(4'd9, 2'd0, 0, 32'h34, "R7 shared mode, mask 0x30");
    chk("R8 masked channel 0", 32'(irq), 32'h0);
    chk("R11 generic ignores mask write", 32'(irq_g), 32'h1);
    rd(4'd1, 2'd0, 1, 32'hFF, "R11 generic mode reads FF");
    @(negedge clk); #1 b_drv = 2'b10;
    wait_cyc(1);
    rd(4'd1, 2'd0, 0, 32'h38, "R7 level bit 3");
    chk("R8 masked channel 1", 32'(irq), 32'h0);
    bus_wr(4'd9, 2'd0, 32'h0000_0010);
    rd(4'd1, 2'd0, 0, 32'h18, "R7 mask write through offset 9");
    chk("R8 unmasked channel 1", 32'(irq), 32'h1);
    @(negedge clk); #1 b_drv = 2'b00;
    wait_cyc(1);
    chk("R8 level drop", 32'(irq), 32'h0);

    // R10 / R11: timing bytes
    bus_wr(4'd3, 2'd0, 32'h0000_005A);
    bus_wr(4'd11, 2'd0, 32'h0000_00A5);
    rd(4'd3, 2'd0, 0, 32'h5A, "R10 timing channel 0");
    rd(4'd11, 2'd0, 0, 32'hA5, "R10 timing channel 1");
    rd(4'd3, 2'd0, 1, 32'hFF, "R11 generic timing reads FF");
    rd(4'd11, 2'd0, 1, 32'hFF, "R11 generic timing ch1 reads FF");

    wait_cyc(2);
    summary();
  end
endmodule